// File: doc/BRIEF.md
# Streaming Binary-to-ASCII Decimal Converter

This block takes an unsigned binary word and streams it out as five ASCII decimal characters, most significant digit first. A serializer downstream can therefore send each character as soon as it appears. Each digit comes from a restoring compare-and-subtract of the working value against eight, four, two and one times the top decimal weight. Each compare that succeeds sets one bit of the digit. The remainder is then scaled by ten with two shifts and one adder. The datapath has no divider and no modulo unit.

Both data sides use valid/ready. An input word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. An output byte is taken when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and its last flag stay frozen. The converter holds at most one word: `in_ready` stays low from the time a word is accepted until its final character has been taken. A word of 100000 or more is still taken by the input handshake, but it yields no characters. Instead, the plain `range_err` pin pulses for one cycle.

Top module: `dec_ascii_stream`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle: `out_valid` low, `range_err` low, `in_ready` high. A conversion in progress is abandoned.
- R2: An accepted word below 100000 makes `out_valid` high in the cycle after the accepting edge, with the first character on `out_data`.
- R3: Every conversion of an in-range word yields exactly five bytes, most significant digit first. Each byte is 0x30 OR'd with the digit value, so bits 7:4 are 0x3 and bits 3:0 hold the digit.
- R4: Each digit equals the matching decimal digit of the input word, including zero-padded leading digits. Examples: 0 gives "00000", 99999 gives "99999", 9999 gives "09999".
- R5: `out_last` is high with the fifth byte and low with the first four.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged on the next cycle. No byte is lost or repeated.
- R7: `in_ready` is low whenever `out_valid` is high. It rises in the cycle after the edge that takes the fifth byte.
- R8: An accepted word of 100000 or more sets `range_err` high for exactly the one cycle after the accepting edge. It produces no bytes and leaves `in_ready` high. A word of 99999 is converted normally.
- R9: With `out_ready` held high, the five bytes of a conversion appear on five consecutive cycles, one digit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word (idle) |
| in_data | input | 17 | Unsigned binary word |
| out_valid | output | 1 | ASCII byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | ASCII decimal character |
| out_last | output | 1 | Marks the fifth character |
| range_err | output | 1 | One-cycle pulse for a rejected word |

## Verification
The assertions assume that `out_ready` can take any value in any cycle. They also assume that `in_valid` and `in_data` are only meaningful while the block is idle. None of them relies on the producer holding a word steady while `in_ready` is low. The stimulus drives every input on the falling clock edge and keeps `in_data` inside its 17 bits, so about a quarter of the random words fall in the rejected range above 99999. Back-pressure is applied in three ways: held low for several cycles, left high throughout, and toggled pseudo-randomly. A reset is also asserted partway through a conversion.

// File: rtl/dec_ascii_pkg.sv
package dec_ascii_pkg;

  localparam logic [7:0] ASCII_ZERO = 8'h30;

  // ten to the power n, evaluated at elaboration
  function automatic int unsigned pow10(input int n);
    int unsigned acc;
    acc = 1;
    for (int i = 0; i < n; i++) acc = acc * 10;
    return acc;
  endfunction

endpackage

// File: rtl/dec_digit_step.sv
// One digit step: restoring subtract against 8,4,2,1 x WEIGHT, then rem*10.
module dec_digit_step #(
  parameter int          WORK_W = 20,
  parameter int unsigned WEIGHT = 10000
) (
  input  logic [WORK_W-1:0] work_i,
  output logic [3:0]        digit_o,
  output logic [WORK_W-1:0] next_o
);
  localparam int STAGES = 4;

  logic [WORK_W-1:0] chain [0:STAGES];
  logic [WORK_W-1:0] rem;

  assign chain[0] = work_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned THR_INT = WEIGHT * (1 << (STAGES - 1 - k));
    localparam logic [WORK_W-1:0] THR = WORK_W'(THR_INT);
    logic hit;
    assign hit = chain[k] >= THR;
    assign chain[k+1] = hit ? (chain[k] - THR) : chain[k];
    assign digit_o[STAGES-1-k] = hit;
  end

  assign rem    = chain[STAGES];
  // times ten by shift-and-add: 8x + 2x
  assign next_o = (rem << 3) + (rem << 1);

endmodule

// File: rtl/dec_seq_ctrl.sv
// Tracks the conversion in progress and the digit position.
module dec_seq_ctrl #(
  parameter int NDIG = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic reject_i,
  input  logic advance_i,
  output logic busy_o,
  output logic final_o,
  output logic err_o
);
  localparam int CNT_W = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NDIG - 1);

  logic [CNT_W-1:0] pos_q;
  logic             busy_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject_i;
      if (start_i) begin
        busy_q <= 1'b1;
        pos_q  <= '0;
      end else if (advance_i) begin
        if (pos_q == LAST_POS) begin
          busy_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign final_o = busy_q && (pos_q == LAST_POS);
  assign err_o   = err_q;

  // R7: a started conversion keeps running until its final digit leaves
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(advance_i && final_o)) |=> busy_q);

  // R5: the final-position flag never appears without a conversion
  a_r5_final_in_busy: assert property (@(posedge clk) disable iff (rst)
    final_o |-> busy_q);

  // R3: position counter stays inside the five digit slots
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_POS);

  // R8: a reject pulse never coexists with a conversion
  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy_q);

endmodule

// File: rtl/dec_ascii_stream.sv
module dec_ascii_stream
  import dec_ascii_pkg::*;
#(
  parameter int IN_W = 17,
  parameter int NDIG = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            range_err
);
  localparam int unsigned LIMIT  = pow10(NDIG);
  localparam int unsigned TOP_WT = pow10(NDIG - 1);
  localparam int          WORK_W = IN_W + 3;
  localparam logic [WORK_W-1:0] LIMIT_W = WORK_W'(LIMIT);

  logic [WORK_W-1:0] work_q;
  logic [WORK_W-1:0] work_next;
  logic [WORK_W-1:0] in_ext;
  logic [3:0]        digit;
  logic              busy, final_pos;
  logic              accept, in_ok, take;

  assign in_ext = WORK_W'(in_data);
  assign in_ok  = in_ext < LIMIT_W;
  assign accept = in_valid && in_ready;
  assign take   = out_valid && out_ready;

  dec_seq_ctrl #(.NDIG(NDIG)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (accept && in_ok),
    .reject_i (accept && !in_ok),
    .advance_i(take),
    .busy_o   (busy),
    .final_o  (final_pos),
    .err_o    (range_err)
  );

  dec_digit_step #(.WORK_W(WORK_W), .WEIGHT(TOP_WT)) u_step (
    .work_i (work_q),
    .digit_o(digit),
    .next_o (work_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
    end else if (accept && in_ok) begin
      work_q <= in_ext;
    end else if (take) begin
      work_q <= work_next;
    end
  end

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_data  = ASCII_ZERO | {4'h0, digit};
  assign out_last  = final_pos;

  // R1: reset returns the stream to idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && !range_err && in_ready));

  // R2: an in-range word yields a first, non-final byte next cycle
  a_r2_first_digit: assert property (@(posedge clk) disable iff (rst)
    (accept && in_ok) |=> (out_valid && !out_last));

  // R3 / R4: bytes are ASCII decimal digits
  a_r3_ascii_digit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[7:4] == 4'h3 && out_data[3:0] <= 4'd9));

  // R4: working value stays below the decimal limit (no overflow of times ten)
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (work_q < LIMIT_W));

  // R6: stalled byte is held
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  // R7: no new word while bytes are pending
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R7: idle right after the final byte is taken
  a_r7_ready_after_last: assert property (@(posedge clk) disable iff (rst)
    (take && out_last) |=> in_ready);

  // R8: out-of-range word flags an error and starts nothing
  a_r8_reject: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_ok) |=> (range_err && !out_valid && in_ready));

endmodule

// File: tb/dec_ascii_stream_bench.sv
module dec_ascii_stream_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [16:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_last;
  logic        range_err;

  always #4 clk = ~clk;   // 125 MHz

  dec_ascii_stream u_dec_ascii_stream (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .range_err(range_err)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [8:0] exp_q [$];     // {last, byte}
  int  rdy_mode = 0;         // 0 always ready, 1 random, 2 manual
  bit  manual_rdy = 1'b1;
  logic [31:0] rlfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // out_ready driver
  always @(negedge clk) begin
    rlfsr = {rlfsr[30:0], rlfsr[31] ^ rlfsr[21] ^ rlfsr[1] ^ rlfsr[0]};
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= rlfsr[0] | rlfsr[5];
      default: out_ready <= manual_rdy;
    endcase
  end

  // monitor / scoreboard
  logic [8:0] prev_item;
  bit         prev_stall = 0;
  always @(negedge clk) begin
    #3;
    if (rst) begin
      prev_stall = 0;
    end else begin
      if (prev_stall)
        check(out_valid && {out_last, out_data} == prev_item, "R6",
              "stalled byte held", int'({out_valid, out_last, out_data}),
              int'({1'b1, prev_item}));
      if (out_valid)
        check(!in_ready, "R7", "in_ready low while busy", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected byte", int'(out_data), -1);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R3/R4/R5", "byte and last flag",
                int'({out_last, out_data}), int'(e));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_item  = {out_last, out_data};
    end
  end

  task automatic push_expected(input int v);
    int p;
    p = 10000;
    for (int i = 0; i < 5; i++) begin
      exp_q.push_back({(i == 4), 8'h30 | 8'((v / p) % 10)});
      p = p / 10;
    end
  endtask

  // driver: offers one word, returns at the falling edge after acceptance
  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 17'(v);
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
    if (v < 100000) push_expected(v);
    @(negedge clk);
    in_valid = 1'b0;
    if (v >= 100000) begin
      #3;
      check(range_err && !out_valid && in_ready, "R8", "reject pulse",
            int'({range_err, out_valid, in_ready}), 3'b101);
      @(negedge clk);
      #3;
      check(!range_err && !out_valid, "R8", "pulse one cycle, no bytes",
            int'({range_err, out_valid}), 0);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    check(!out_valid && in_ready && !range_err, "R1", "reset state",
          int'({out_valid, in_ready, range_err}), 3'b010);
    @(negedge clk);
    rst = 1'b0;

    // R9 / R2 / R7: back-to-back digits with ready held high
    send(12345);
    for (int i = 0; i < 5; i++) begin
      #3;
      check(out_valid, "R9", "consecutive digit", int'(out_valid), 1);
      @(negedge clk);
    end
    #3;
    check(!out_valid && in_ready, "R7", "ready after fifth byte",
          int'({out_valid, in_ready}), 2'b01);

    // R4 boundary and pattern values
    send(0);      send(99999);  send(9999);  send(10000);
    send(80000);  send(54321);  send(90909); send(70000); send(1);
    drain();

    // R8: out of range words, with the edge value 99999 converted
    send(100000); send(131071); send(99999); drain();
    send(100001); drain();

    // R6: long stall on the first byte
    @(negedge clk); #1;
    manual_rdy = 1'b0; rdy_mode = 2;
    send(40506);
    for (int i = 0; i < 4; i++) begin
      #3;
      check(out_valid && out_data == 8'h34 && !out_last, "R6",
            "first byte frozen", int'(out_data), 8'h34);
      @(negedge clk);
    end
    #1; manual_rdy = 1'b1;
    drain();
    rdy_mode = 0;

    // R1: reset in the middle of a conversion
    send(77777);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #3;
    exp_q.delete();
    check(!out_valid && in_ready && !range_err, "R1", "mid-stream reset",
          int'({out_valid, in_ready, range_err}), 3'b010);
    @(negedge clk);
    rst = 1'b0;

    // random words under random back-pressure
    rdy_mode = 1;
    begin
      logic [31:0] s;
      s = 32'h0BAD_5EED;
      for (int n = 0; n < 300; n++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        send(int'(s[16:0]));
      end
    end
    drain();
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule